// File: doc/BRIEF.md
# Gain Calibration Sequencer

This block runs a single-point gain calibration on up to `NCH` measurement slots. Even slots carry voltage and odd slots carry current. A host sets two shared targets through a small register port. The voltage target applies to every even slot and the current target to every odd slot. The host also sets a cycle count, then writes a command word. The low bits of the command word pick the slots, and the byte at bits 23:16 starts the run.

In gain mode the sequencer first forces each picked gain to unity. It then sums the per-cycle RMS results over the programmed number of measurement cycles. For each picked slot, in ascending order, it divides the target by the average using one shared restoring divider. A valid S.21 quotient becomes the new gain. At the end of the run the command word reports the outcome: the start byte is cleared, the bit of each successful slot is cleared, and the bit of each failed slot stays set. In offset mode the block only waits out the measurement window, then clears the start byte and leaves the slot bits as written.

Top module: `gain_cal_seq`

## Requirements
- R1: After reset the command word reads 0, both targets read 0, the cycle count reads 1, every gain reads 0x200000 (S.21 unity) and `busy` is low.
- R2: Register addresses are 0 for the command word, 1 for the voltage target, 2 for the current target, 3 for the cycle count and 4+c for the gain of slot c. Command bit c picks slot c. While idle, a command write with a nonzero value in bits 23:16 starts a run and raises `busy`. When bit 16 is set the run is a gain run, and every picked slot's gain reads 0x200000 while `busy` is high.
- R3: During a run, every `rms_valid` strobe adds each slot's signed S.23 sample to that slot's sum. The measurement window closes on the strobe that brings the strobe count up to the cycle count, and a count of 0 acts as 1. Strobes while idle are not counted.
- R4: A picked slot on an even index uses the voltage target T and one on an odd index uses the current target. With N strobes and a sum S, its gain becomes floor(T·N·2^21 / S) and its command bit is cleared.
- R5: A slot that is not picked keeps its gain and its command bit across a run.
- R6: If the quotient is 2^23 or larger, the slot fails: its gain stays 0x200000 and its command bit stays set.
- R7: When a run ends, bits 23:16 of the command word read 0 and `busy` returns low.
- R8: A picked slot whose sum is zero or negative fails without a division: its gain stays 0x200000 and its command bit stays set.
- R9: A run started with bits 23:16 nonzero and bit 16 clear is an offset run. After the window closes, bits 23:16 are cleared, the slot bits are kept whatever their value, and no gain changes.
- R10: While `busy` is high, writes to any address, the command word included, have no effect.
- R11: A target above 5931584 (0x5A8240, 70.7 % of S.23 full scale), or a negative target, makes every picked slot that uses it fail as in R6. A target of exactly 0x5A8240 is accepted.
- R12: An `rms_valid` strobe in the same cycle as the starting command write is not counted in the sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | W | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | W | Read data for `rd_addr`, combinational |
| rms_valid | input | 1 | One strobe per measurement cycle |
| rms_in | input | NCH·W | Signed S.23 RMS sample per slot, slot c at bits c·W upward |
| busy | output | 1 | High from the start write until the run ends |

## Verification
Two events can land in the same clock edge. One is the host's starting command write, which coincides with an RMS strobe. The other is a host write that arrives while the sequencer is still accumulating and therefore owns the registers. The bench provokes the first by raising `rms_valid` with a deliberately large sample in the very cycle of the command write. It judges the outcome by the gains, which must match a reference computed only from the later strobes. For the second, the bench writes a new target, cycle count, gain and command during the window. It then reads all of them back after `busy` falls and checks that the run used only the values set before the start.

// File: rtl/gcal_pkg.sv
package gcal_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ACC,
        S_PICK,
        S_DIV,
        S_FIN
    } gcal_st_e;

    localparam int ADDR_CMD  = 0;
    localparam int ADDR_VT   = 1;
    localparam int ADDR_IT   = 2;
    localparam int ADDR_CYC  = 3;
    localparam int GAIN_BASE = 4;

    localparam int OP_LO   = 16;
    localparam int OP_HI   = 23;
    localparam int OP_GAIN = 16;
endpackage

// File: rtl/gcal_accum.sv
module gcal_accum #(
    parameter int NCH   = 4,
    parameter int W     = 24,
    parameter int ACC_W = 40
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr,
    input  logic                            en,
    input  logic [NCH*W-1:0]                din,
    output logic [NCH-1:0][ACC_W-1:0]       acc
);
    localparam int EXT_W = ACC_W - W;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [ACC_W-1:0] sum_d, sum_q;
        logic [ACC_W-1:0] sample;

        assign sample = {{EXT_W{din[c*W+W-1]}}, din[c*W +: W]};

        always_comb begin
            sum_d = sum_q;
            if (clr) begin
                sum_d = '0;
            end else if (en) begin
                sum_d = sum_q + sample;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sum_q <= '0;
            end else begin
                sum_q <= sum_d;
            end
        end

        assign acc[c] = sum_q;
    end
endmodule

// File: rtl/gcal_div.sv
module gcal_div #(
    parameter int NUM_W = 60,
    parameter int DEN_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_W - 1);

    typedef struct packed {
        logic             run;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [DEN_W-1:0] rem;
        logic [DEN_W-1:0] den;
        logic [NUM_W-1:0] n;
        logic [NUM_W-1:0] q;
    } div_t;

    div_t d, q;
    logic [DEN_W:0] trial;
    logic [DEN_W:0] diff;
    logic           qbit;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem, q.n[NUM_W-1]};
        diff   = trial - {1'b0, q.den};
        qbit   = (trial >= {1'b0, q.den});
        if (start) begin
            d.run = 1'b1;
            d.cnt = '0;
            d.rem = '0;
            d.den = den;
            d.n   = num;
            d.q   = '0;
        end else if (q.run) begin
            d.rem = qbit ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            d.n   = {q.n[NUM_W-2:0], 1'b0};
            d.q   = {q.q[NUM_W-2:0], qbit};
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == LAST) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign quo  = q.q;
endmodule

// File: rtl/gain_cal_seq.sv
module gain_cal_seq
    import gcal_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int W     = 24,
    parameter int CNT_W = 16,
    parameter int FRAC  = 21,
    parameter int AW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [W-1:0]      rd_data,
    input  logic              rms_valid,
    input  logic [NCH*W-1:0]  rms_in,
    output logic              busy
);
    localparam int ACC_W = W + CNT_W;
    localparam int NUM_W = (W - 1) + CNT_W + FRAC;
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [W-1:0] UNITY = {{(W-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};
    localparam longint TGT_LIM_L = ((longint'(1) << (W - 1)) * 7071) / 10000;
    localparam logic [W-1:0] TGT_LIM = W'(TGT_LIM_L);

    typedef struct packed {
        gcal_st_e                st;
        logic [W-1:0]            cmd;
        logic [W-1:0]            vt;
        logic [W-1:0]            it;
        logic [CNT_W-1:0]        ncyc;
        logic [CNT_W-1:0]        cnt;
        logic [NCH-1:0][W-1:0]   gain;
        logic [CH_W-1:0]         ch;
    } regs_t;

    regs_t d, q;

    logic                        acc_clr, acc_en;
    logic [NCH-1:0][ACC_W-1:0]   acc_w;
    logic                        div_go, div_done;
    logic [NUM_W-1:0]            div_num, div_quo;
    logic [W-1:0]                tgt_sel;
    logic                        tgt_bad;
    logic [CNT_W-1:0]            n_eff, cnt_nx;
    logic [ACC_W-1:0]            acc_sel;
    logic                        sum_bad;
    logic                        adv;

    logic [W-1:0]                cmd_q, vt_q, it_q, ncyc_q;
    logic [NCH-1:0][W-1:0]       gain_q;

    assign cmd_q  = q.cmd;
    assign vt_q   = q.vt;
    assign it_q   = q.it;
    assign ncyc_q = W'(q.ncyc);
    assign gain_q = q.gain;

    gcal_accum #(.NCH(NCH), .W(W), .ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .en    (acc_en),
        .din   (rms_in),
        .acc   (acc_w)
    );

    gcal_div #(.NUM_W(NUM_W), .DEN_W(ACC_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_go),
        .num   (div_num),
        .den   (acc_sel),
        .done  (div_done),
        .quo   (div_quo)
    );

    always_comb begin
        d       = q;
        acc_clr = 1'b0;
        acc_en  = 1'b0;
        div_go  = 1'b0;
        adv     = 1'b0;
        tgt_sel = q.ch[0] ? q.it : q.vt;
        tgt_bad = tgt_sel[W-1] || (tgt_sel > TGT_LIM);
        n_eff   = (q.ncyc == '0) ? CNT_W'(1) : q.ncyc;
        cnt_nx  = q.cnt + 1'b1;
        div_num = (NUM_W'(tgt_sel[W-2:0]) * NUM_W'(n_eff)) << FRAC;
        acc_sel = acc_w[q.ch];
        sum_bad = acc_sel[ACC_W-1] || (acc_sel == '0);

        case (q.st)
            S_IDLE: begin
                if (wr_en) begin
                    if (wr_addr == AW'(ADDR_CMD)) begin
                        d.cmd = wr_data;
                        if (wr_data[OP_HI:OP_LO] != '0) begin
                            d.st    = S_ACC;
                            d.cnt   = '0;
                            d.ch    = '0;
                            acc_clr = 1'b1;
                            if (wr_data[OP_GAIN]) begin
                                for (int c = 0; c < NCH; c++) begin
                                    if (wr_data[c]) begin
                                        d.gain[c] = UNITY;
                                    end
                                end
                            end
                        end
                    end else if (wr_addr == AW'(ADDR_VT)) begin
                        d.vt = wr_data;
                    end else if (wr_addr == AW'(ADDR_IT)) begin
                        d.it = wr_data;
                    end else if (wr_addr == AW'(ADDR_CYC)) begin
                        d.ncyc = wr_data[CNT_W-1:0];
                    end else begin
                        for (int c = 0; c < NCH; c++) begin
                            if (wr_addr == AW'(GAIN_BASE + c)) begin
                                d.gain[c] = wr_data;
                            end
                        end
                    end
                end
            end
            S_ACC: begin
                if (rms_valid) begin
                    acc_en = 1'b1;
                    d.cnt  = cnt_nx;
                    if (cnt_nx >= n_eff) begin
                        d.st = q.cmd[OP_GAIN] ? S_PICK : S_FIN;
                    end
                end
            end
            S_PICK: begin
                if (q.cmd[q.ch]) begin
                    if (tgt_bad || sum_bad) begin
                        adv = 1'b1;
                    end else begin
                        div_go = 1'b1;
                        d.st   = S_DIV;
                    end
                end else begin
                    adv = 1'b1;
                end
            end
            S_DIV: begin
                if (div_done) begin
                    if (div_quo[NUM_W-1:W-1] == '0) begin
                        d.gain[q.ch] = div_quo[W-1:0];
                        d.cmd[q.ch]  = 1'b0;
                    end
                    adv = 1'b1;
                end
            end
            S_FIN: begin
                d.cmd[OP_HI:OP_LO] = '0;
                d.st               = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase

        if (adv) begin
            if (q.ch == CH_W'(NCH - 1)) begin
                d.st = S_FIN;
            end else begin
                d.ch = q.ch + 1'b1;
                d.st = S_PICK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= S_IDLE;
            q.cmd  <= '0;
            q.vt   <= '0;
            q.it   <= '0;
            q.ncyc <= CNT_W'(1);
            q.cnt  <= '0;
            q.ch   <= '0;
            for (int c = 0; c < NCH; c++) begin
                q.gain[c] <= UNITY;
            end
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(ADDR_CMD)) begin
            rd_data = cmd_q;
        end else if (rd_addr == AW'(ADDR_VT)) begin
            rd_data = vt_q;
        end else if (rd_addr == AW'(ADDR_IT)) begin
            rd_data = it_q;
        end else if (rd_addr == AW'(ADDR_CYC)) begin
            rd_data = ncyc_q;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (rd_addr == AW'(GAIN_BASE + c)) begin
                    rd_data = gain_q[c];
                end
            end
        end
    end

    assign busy = (q.st != S_IDLE);
endmodule

// File: rtl/gcal_chk.sv
module gcal_chk
    import gcal_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int W    = 24,
    parameter int FRAC = 21
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic                    busy,
    input logic [W-1:0]            cmd_w,
    input logic [W-1:0]            vt_w,
    input logic [W-1:0]            it_w,
    input logic [W-1:0]            ncyc_w,
    input logic [NCH-1:0][W-1:0]   gain_w
);
    localparam logic [W-1:0] UNITY = {{(W-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};

    // R10: configuration is frozen while a run owns the block
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_en |=> $stable(vt_w) && $stable(it_w) && $stable(ncyc_w));

    // R7: the start byte is empty once the run is over
    a_r7_field_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> cmd_w[OP_HI:OP_LO] == '0);

    // R9: in an offset run the slot bits never move
    a_r9_offset_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !cmd_w[OP_GAIN] |=> cmd_w[NCH-1:0] == $past(cmd_w[NCH-1:0]));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // R2: picked slots start a gain run at unity
        a_r2_unity_at_start: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy) && cmd_w[OP_GAIN] && cmd_w[c] |-> gain_w[c] == UNITY);

        // R6: a gain written by the sequencer is never negative
        a_r6_gain_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            busy && (gain_w[c] != $past(gain_w[c])) |-> !gain_w[c][W-1]);
    end
endmodule

bind gain_cal_seq gcal_chk #(.NCH(NCH), .W(W), .FRAC(FRAC)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .busy   (busy),
    .cmd_w  (cmd_q),
    .vt_w   (vt_q),
    .it_w   (it_q),
    .ncyc_w (ncyc_q),
    .gain_w (gain_q)
);

// File: tb/tb_gain_cal_seq.sv
module tb_gain_cal_seq;
    localparam int NCH = 4;
    localparam int W   = 24;
    localparam int AW  = 4;
    localparam logic [23:0] UNITY = 24'h200000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [W-1:0]      wr_data;
    logic [AW-1:0]     rd_addr;
    logic [W-1:0]      rd_data;
    logic              rms_valid;
    logic [NCH*W-1:0]  rms_in;
    logic              busy;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    longint s[4];

    always #4 clk = ~clk;

    gain_cal_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .rms_valid(rms_valid), .rms_in(rms_in), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [23:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [23:0] v);
        @(negedge clk);
        rd_addr = AW'(a);
        #1 v = rd_data;
    endtask

    task automatic clr_sums();
        for (int c = 0; c < 4; c++) s[c] = 0;
    endtask

    task automatic strobe(input logic [23:0] a, b, c, d, input bit count);
        @(negedge clk);
        rms_valid = 1'b1; rms_in = {d, c, b, a};
        @(negedge clk);
        rms_valid = 1'b0;
        if (count) begin
            s[0] += longint'($signed(a)); s[1] += longint'($signed(b));
            s[2] += longint'($signed(c)); s[3] += longint'($signed(d));
        end
    endtask

    task automatic start(input logic [23:0] v, input bit coinc);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = '0; wr_data = v;
        if (coinc) begin
            rms_valid = 1'b1; rms_in = {4{24'h7FFFFF}};
        end
        @(negedge clk);
        wr_en = 1'b0; rms_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    function automatic logic [24:0] exp_g(input logic [23:0] t, input int n, input longint sum);
        longint num, qt;
        if (t[23] || t > 24'h5A8240 || sum <= 0) return {1'b0, UNITY};
        num = (longint'(t) * n) <<< 21;
        qt  = num / sum;
        if (qt >= (longint'(1) << 23)) return {1'b0, UNITY};
        return {1'b1, qt[23:0]};
    endfunction

    task automatic t_reset();
        logic [23:0] v;
        check("R1 busy", 32'(busy), 0);
        rd(0, v); check("R1 cmd", 32'(v), 0);
        rd(1, v); check("R1 vtarget", 32'(v), 0);
        rd(3, v); check("R1 cycles", 32'(v), 1);
        for (int c = 0; c < 4; c++) begin
            rd(4 + c, v); check("R1 gain", 32'(v), 32'(UNITY));
        end
    endtask

    task automatic t_basic();
        logic [23:0] v;
        logic [24:0] e;
        wr(6, 24'h123456); wr(7, 24'h0ABCDE);
        wr(1, 24'h400000); wr(2, 24'h200000); wr(3, 4);
        wr(4, 24'h111111);
        clr_sums();
        start(24'h010003, 0);
        check("R2 busy after start", 32'(busy), 1);
        rd(4, v); check("R2 unity forced", 32'(v), 32'(UNITY));
        for (int i = 0; i < 4; i++) strobe(24'h300000, 24'h180000, 24'h050000, 24'h060000, 1);
        wait_idle();
        check("R7 busy low", 32'(busy), 0);
        e = exp_g(24'h400000, 4, s[0]); rd(4, v); check("R4 gain0", 32'(v), 32'(e[23:0]));
        e = exp_g(24'h200000, 4, s[1]); rd(5, v); check("R4 gain1", 32'(v), 32'(e[23:0]));
        rd(0, v); check("R4 R7 cmd cleared", 32'(v), 0);
        rd(6, v); check("R5 gain2 kept", 32'(v), 32'h123456);
        rd(7, v); check("R5 gain3 kept", 32'(v), 32'h0ABCDE);
    endtask

    task automatic t_vary();
        logic [23:0] v;
        logic [24:0] e;
        wr(1, 24'h300000); wr(2, 24'h250000); wr(3, 3);
        clr_sums();
        strobe(24'h010000, 24'h010000, 24'h010000, 24'h010000, 0);
        start(24'h01000F, 1);
        strobe(24'h2A0000, 24'h310000, 24'h280000, 24'h220000, 1);
        repeat (3) @(negedge clk);
        strobe(24'h2E1234, 24'h2F0000, 24'h2B5555, 24'h260000, 1);
        check("R3 window open", 32'(busy), 1);
        strobe(24'h2C0101, 24'h330000, 24'h291111, 24'h240000, 1);
        wait_idle();
        for (int c = 0; c < 4; c++) begin
            e = exp_g((c % 2 == 1) ? 24'h250000 : 24'h300000, 3, s[c]);
            rd(4 + c, v); check("R3 R12 gain", 32'(v), 32'(e[23:0]));
        end
        rd(0, v); check("R4 cmd cleared", 32'(v), 0);
    endtask

    task automatic t_fail();
        logic [23:0] v;
        logic [24:0] e;
        wr(1, 24'h200000); wr(2, 24'h500000); wr(3, 2);
        for (int c = 0; c < 4; c++) wr(4 + c, 24'h0F0000);
        clr_sums();
        start(24'h01000F, 0);
        for (int i = 0; i < 2; i++) strobe(24'h000000, 24'h080000, 24'hF00000, 24'h600000, 1);
        wait_idle();
        rd(0, v); check("R6 R8 cmd bits", 32'(v), 32'h000007);
        rd(4, v); check("R8 zero sum", 32'(v), 32'(UNITY));
        rd(5, v); check("R6 overflow", 32'(v), 32'(UNITY));
        rd(6, v); check("R8 negative sum", 32'(v), 32'(UNITY));
        e = exp_g(24'h500000, 2, s[3]);
        rd(7, v); check("R4 gain3", 32'(v), 32'(e[23:0]));
    endtask

    task automatic t_limit();
        logic [23:0] v;
        logic [24:0] e;
        wr(1, 24'h5A8241); wr(2, 24'h5A8240); wr(3, 1);
        clr_sums();
        start(24'h01000F, 0);
        strobe(24'h600000, 24'h600000, 24'h600000, 24'h610000, 1);
        wait_idle();
        rd(0, v); check("R11 cmd bits", 32'(v), 32'h000005);
        rd(4, v); check("R11 over limit", 32'(v), 32'(UNITY));
        e = exp_g(24'h5A8240, 1, s[1]);
        rd(5, v); check("R11 at limit", 32'(v), 32'(e[23:0]));
        wr(1, 24'h900000);
        clr_sums();
        start(24'h010001, 0);
        strobe(24'h400000, 24'h0, 24'h0, 24'h0, 1);
        wait_idle();
        rd(0, v); check("R11 negative target", 32'(v), 32'h000001);
    endtask

    task automatic t_offset();
        logic [23:0] v, g2;
        wr(4, 24'h1F0000); wr(3, 2);
        rd(6, g2);
        start(24'h020005, 0);
        strobe(24'h100000, 24'h100000, 24'h100000, 24'h100000, 0);
        check("R9 window open", 32'(busy), 1);
        strobe(24'h100000, 24'h100000, 24'h100000, 24'h100000, 0);
        wait_idle();
        rd(0, v); check("R9 bits kept", 32'(v), 32'h000005);
        rd(4, v); check("R9 gain0 untouched", 32'(v), 32'h1F0000);
        rd(6, v); check("R9 gain2 untouched", 32'(v), 32'(g2));
    endtask

    task automatic t_busy_writes();
        logic [23:0] v, g1;
        wr(1, 24'h200000); wr(3, 2);
        rd(5, g1);
        start(24'h010001, 0);
        wr(1, 24'h100000); wr(3, 9); wr(5, 24'h333333); wr(0, 24'h010002);
        strobe(24'h200000, 24'h0, 24'h0, 24'h0, 0);
        strobe(24'h200000, 24'h0, 24'h0, 24'h0, 0);
        wait_idle();
        rd(4, v); check("R10 gain uses old target", 32'(v), 32'(UNITY));
        rd(1, v); check("R10 vtarget kept", 32'(v), 32'h200000);
        rd(3, v); check("R10 cycles kept", 32'(v), 2);
        rd(5, v); check("R10 gain1 kept", 32'(v), 32'(g1));
        rd(0, v); check("R10 cmd not replaced", 32'(v), 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; rms_valid = 1'b0; rms_in = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_vary();
        t_fail();
        t_limit();
        t_offset();
        t_busy_writes();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule